// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, made of a segment number and an offset inside that segment, into a physical address. It holds a small table with one entry per segment. Each entry has a physical base, a segment length, a valid flag and three access rights: read, write and execute. Every request is checked in three steps. The segment must be valid. The offset must lie below the length. The kind of access must be allowed by the rights. Only a request that passes all three is relocated by adding the offset to the base.

A supervisor loads table entries through a write port, for example when the running task changes. A lookup takes one clock cycle. The result carries either the physical address or a fault code that tells why the access was refused.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_vld` is 0 and every table entry is invalid, so any request until the first table write faults with code 01.
- R2: `rsp_vld` is 1 in the cycle after a cycle with `req_vld` = 1, and is 0 in the cycle after a cycle with `req_vld` = 0.
- R3: A request to an entry whose valid flag is 0 returns fault code 01. This check takes precedence over the limit and rights checks.
- R4: A request to a valid entry with offset greater than or equal to the entry's length returns fault code 10. This check takes precedence over the rights check. A length of 0 refuses every offset.
- R5: The access kind is encoded 00 read, 01 write, 10 execute. They need rights bit 0, bit 1 and bit 2 respectively. Kind 11 is never allowed. A valid, in-range request whose kind is not allowed returns fault code 11.
- R6: A request that passes every check returns fault code 00 and `rsp_addr` = (base + offset) mod 2^PA_W. A faulting request returns `rsp_addr` = 0.
- R7: When `tbl_we` is 1, the entry at `tbl_idx` takes the new base, length, valid flag and rights. A request presented in the same cycle still sees the old entry, and a request presented in the next cycle sees the new one.
- R8: A table write changes only the addressed entry. The other entries translate exactly as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | SEG_W | Entry to write |
| tbl_base | input | PA_W | New physical base |
| tbl_len | input | OFF_W+1 | New segment length |
| tbl_ok | input | 1 | New valid flag |
| tbl_perm | input | 3 | New rights: bit0 read, bit1 write, bit2 execute |
| req_vld | input | 1 | Translation request valid |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| rsp_vld | output | 1 | Result valid |
| rsp_addr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 none, 01 invalid, 10 limit, 11 rights |

## Verification
The bench builds the block with SEG_W=2, OFF_W=4 and PA_W=6, which gives four entries, sixteen offsets and a 64-byte physical space. With these values it can sweep every segment, offset and access kind against two complete table setups. The small physical space lets a base near the top wrap around, and lengths of 0 and 16 test both ends of the limit check. Entries that are invalid yet carry full rights, and out-of-range offsets into segments without rights, show the fault priority directly. The same-cycle write and request case is checked on its own.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [SEG_W-1:0] tbl_idx,
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [OFF_W:0]   tbl_len,
  input  logic             tbl_ok,
  input  logic [2:0]       tbl_perm,
  input  logic             req_vld,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_kind,
  output logic             rsp_vld,
  output logic [PA_W-1:0]  rsp_addr,
  output logic [1:0]       rsp_fault
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int LEN_W = OFF_W + 1;
  localparam logic [1:0] F_NONE = 2'b00;
  localparam logic [1:0] F_INV  = 2'b01;
  localparam logic [1:0] F_LIM  = 2'b10;
  localparam logic [1:0] F_PERM = 2'b11;

  logic [PA_W-1:0]  base_q [NSEG];
  logic [LEN_W-1:0] len_q  [NSEG];
  logic [2:0]       perm_q [NSEG];
  logic [NSEG-1:0]  ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ok_q <= '0;
    else if (tbl_we) ok_q[tbl_idx] <= tbl_ok;
  end

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      base_q[tbl_idx] <= tbl_base;
      len_q[tbl_idx]  <= tbl_len;
      perm_q[tbl_idx] <= tbl_perm;
    end
  end

  logic            hit_ok, over, allowed;
  logic [1:0]      fault_d;
  logic [PA_W-1:0] sum;

  assign hit_ok  = ok_q[req_seg];
  assign over    = {1'b0, req_off} >= len_q[req_seg];
  assign allowed = (req_kind == 2'b11) ? 1'b0 : perm_q[req_seg][req_kind];
  assign sum     = base_q[req_seg] + PA_W'(req_off);
  assign fault_d = !hit_ok ? F_INV : over ? F_LIM : !allowed ? F_PERM : F_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= F_NONE;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_fault <= fault_d;
        rsp_addr  <= (fault_d == F_NONE) ? sum : '0;
      end
    end
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld); // R2
  AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld); // R2
  AST_INVALID_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && !ok_q[req_seg] |=> rsp_fault == F_INV); // R3
  AST_LIMIT_BEFORE_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && ok_q[req_seg] && ({1'b0, req_off} >= len_q[req_seg]) |=> rsp_fault == F_LIM); // R4
  AST_WRITE_NEEDS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && ok_q[req_seg] && !over && req_kind == 2'b01 && !perm_q[req_seg][1]
    |=> rsp_fault == F_PERM); // R5
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_fault != F_NONE |-> rsp_addr == '0); // R6
  AST_RELOCATE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld && rsp_fault == F_NONE
    |-> rsp_addr - $past(base_q[req_seg]) == $past(PA_W'(req_off))); // R6
endmodule

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [1:0] tbl_idx = '0;
  logic [5:0] tbl_base = '0;
  logic [4:0] tbl_len = '0;
  logic       tbl_ok = 1'b0;
  logic [2:0] tbl_perm = '0;
  logic       req_vld = 1'b0;
  logic [1:0] req_seg = '0;
  logic [3:0] req_off = '0;
  logic [1:0] req_kind = '0;
  logic       rsp_vld;
  logic [5:0] rsp_addr;
  logic [1:0] rsp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] m_base [4];
  logic [4:0] m_len  [4];
  logic       m_ok   [4];
  logic [2:0] m_perm [4];

  always #5 clk = ~clk;

  seg_xlate #(.SEG_W(2), .OFF_W(4), .PA_W(6)) u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_base(tbl_base), .tbl_len(tbl_len), .tbl_ok(tbl_ok), .tbl_perm(tbl_perm),
    .req_vld(req_vld), .req_seg(req_seg), .req_off(req_off), .req_kind(req_kind),
    .rsp_vld(rsp_vld), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(int s, int o, int k);
    if (!m_ok[s]) return 2'b01;
    if (o >= int'(m_len[s])) return 2'b10;
    if (k == 3 || !m_perm[s][k]) return 2'b11;
    return 2'b00;
  endfunction

  task automatic put_entry(int i, int b, int l, bit ok, int p);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = i[1:0]; tbl_base = b[5:0];
    tbl_len = l[4:0]; tbl_ok = ok; tbl_perm = p[2:0];
    @(negedge clk);
    tbl_we = 1'b0;
    m_base[i] = b[5:0]; m_len[i] = l[4:0]; m_ok[i] = ok; m_perm[i] = p[2:0];
  endtask

  task automatic xlate(int s, int o, int k, string tag_in);
    logic [1:0] ef;
    logic [5:0] ea;
    string tag;
    ef = exp_fault(s, o, k);
    ea = (ef == 2'b00) ? 6'((int'(m_base[s]) + o) % 64) : 6'd0;
    if (tag_in != "") tag = tag_in;
    else if (ef == 2'b01) tag = "R3";
    else if (ef == 2'b10) tag = "R4";
    else if (ef == 2'b11) tag = "R5";
    else tag = "R6";
    @(negedge clk);
    req_vld = 1'b1; req_seg = s[1:0]; req_off = o[3:0]; req_kind = k[1:0];
    @(negedge clk);
    req_vld = 1'b0;
    check("R2", "rsp_vld", int'(rsp_vld), 1);
    check(tag, "rsp_fault", int'(rsp_fault), int'(ef));
    check(tag, "rsp_addr", int'(rsp_addr), int'(ea));
  endtask

  task automatic sweep();
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 16; o++)
        for (int k = 0; k < 4; k++)
          xlate(s, o, k, "");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = '0; m_len[i] = '0; m_ok[i] = 1'b0; m_perm[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", "rsp_vld after reset", int'(rsp_vld), 0);
    for (int s = 0; s < 4; s++) xlate(s, 0, 0, "R1");

    @(negedge clk);
    check("R2", "rsp_vld idle", int'(rsp_vld), 0);

    put_entry(0, 5, 10, 1'b1, 3'b001);
    put_entry(1, 60, 16, 1'b1, 3'b011);
    put_entry(2, 20, 16, 1'b0, 3'b111);
    put_entry(3, 32, 0, 1'b1, 3'b100);
    sweep();

    put_entry(0, 40, 16, 1'b1, 3'b110);
    put_entry(1, 17, 5, 1'b1, 3'b100);
    put_entry(2, 0, 7, 1'b1, 3'b111);
    put_entry(3, 63, 3, 1'b1, 3'b001);
    sweep();

    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'd0; tbl_base = 6'd10; tbl_len = 5'd4;
    tbl_ok = 1'b1; tbl_perm = 3'b001;
    req_vld = 1'b1; req_seg = 2'd0; req_off = 4'd2; req_kind = 2'b00;
    @(negedge clk);
    tbl_we = 1'b0; req_vld = 1'b0;
    check("R7", "same-cycle fault uses old entry", int'(rsp_fault), 3);
    check("R7", "same-cycle addr", int'(rsp_addr), 0);
    m_base[0] = 6'd10; m_len[0] = 5'd4; m_ok[0] = 1'b1; m_perm[0] = 3'b001;
    xlate(0, 2, 0, "R7");
    xlate(0, 4, 0, "R7");
    for (int s = 1; s < 4; s++)
      for (int o = 0; o < 16; o++) xlate(s, o, 0, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule